// File: doc/BRIEF.md
# Priority Action Slot Packer

A classification rule can ask for up to fourteen different actions to be taken on a matching frame. Each action carries a 16-bit word of parameters. The rule entry holding those words has only a small number of parameter slots. This block takes the request flags and the parameter words and assigns each requested action, in a fixed precedence, to the next free slot. It also builds the 16-bit selector word that records which actions are present and what kind of drop is requested.

A single `start_i` pulse captures all inputs. From then on the packer examines one action per clock cycle, from the highest precedence down to the lowest. It reports the outcome with a one-cycle `done_o` pulse. If more actions are requested than there are slots, the scan stops at the first action that finds no free slot. In that case `ovf_o` is raised together with `done_o`, and the slot contents are not to be used. The requested actions can fill at most four slots, so only the fifth requested action can overflow. The first four precedence levels can therefore never overflow.

Top module: `act_slot_packer`

## Requirements
- R1: After reset, `done_o` and `ovf_o` are 0, and `slots_o` and `sel_word_o` are all zero.
- R2: Requested actions are placed in precedence order. The order is:
  - precedence 0: forward
  - precedence 1: outer VID
  - precedence 2: inner VID
  - precedence 3: filter
  - precedence 4: log
  - precedence 5: remark
  - precedence 6: meter
  - precedence 7: egress tag status
  - precedence 8: mirror
  - precedence 9: normal priority
  - precedence 10: CPU priority
  - precedence 11: outer TPID
  - precedence 12: inner TPID
  - precedence 13: shaper

  Actions that are not requested take no slot.
- R3: The first placed action goes to slot 3 (`slots_o[63:48]`), the next to slot 2, and so on down to slot 0 (`slots_o[15:0]`).
- R4: `act_sel_i` bit 13−p requests the action of precedence p: forward is bit 13 and shaper is bit 0. The selector word equals these 14 flags in bits [13:0]. Bits [15:14] hold the drop code: 01 when `drop_i` is set, 00 otherwise.
- R5: The forward slot word is laid out as follows:
  - bits [15:13]: `fwd_code_i`
  - bit 12: `fwd_bypass_i[2]` (bypass all)
  - bit 11: `fwd_bypass_i[1]` (bypass ingress bandwidth and storm control)
  - bit 10: `fwd_bypass_i[0]` (bypass ingress spanning tree)
  - bits [9:0]: `fwd_data_i`
- R6: The outer VID slot word is 00 in bits [15:14], the 2-bit action code in bits [13:12] and the VID in bits [11:0]. The inner VID slot word uses the same layout.
- R7: When an action is requested while all four slots are used, `done_o` and `ovf_o` rise together in the cycle after that action is examined, and scanning stops.
- R8: Without overflow, `done_o` is a one-cycle pulse with `ovf_o` low. It becomes visible 15 cycles after the cycle in which `start_i` was presented, that is, after 14 examine cycles.
- R9: Slots that receive no action read as zero.
- R10: A `start_i` pulse while a scan is in progress is ignored: inputs are not re-captured and the result is unchanged.
- R11: Each action of precedence 3 to 13 uses its 16-bit word unchanged. That word is taken from `plain_data_i[16k+15:16k]` with k = precedence − 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture inputs and begin a scan |
| act_sel_i | input | 14 | Action request flags, forward at bit 13 |
| drop_i | input | 1 | Request a standard drop |
| fwd_code_i | input | 3 | Forward action code |
| fwd_bypass_i | input | 3 | Bypass flags: all, bandwidth/storm, spanning tree |
| fwd_data_i | input | 10 | Forward parameter |
| ovid_code_i | input | 2 | Outer VID action code |
| ovid_i | input | 12 | Outer VID value |
| ivid_code_i | input | 2 | Inner VID action code |
| ivid_i | input | 12 | Inner VID value |
| plain_data_i | input | 176 | Words for the eleven lower-precedence actions |
| slots_o | output | 64 | Four packed slot words, slot 3 in the top bits |
| sel_word_o | output | 16 | Drop code and action flags |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Slot overflow, valid with done_o |

## Verification
The packer is driven with several kinds of flag sets:
- no flags at all, which shows the selector and zero-fill paths on their own;
- the four highest-precedence actions, which exercise the forward and VID word layouts;
- sparse sets drawn only from lower precedences, which show that slots are assigned by request order rather than by fixed position;
- exactly four low-precedence requests, which reach the final examine step without overflowing.

Overflow is tried twice. In one case the fifth request comes early, which gives a short abort latency. In the other the fifth request is the last action, which separates an abort from a normal finish at the same cycle. A second start pulse given in the middle of a scan checks that the captured inputs are held. Pseudo-random flag sets cover the remaining mixes.

// File: rtl/act_pack_pkg.sv
package act_pack_pkg;
  localparam int ACT_W     = 16;
  localparam int NUM_ACT   = 14;
  localparam int FIXED_ACT = 3;
  localparam int PLAIN_ACT = NUM_ACT - FIXED_ACT;
  localparam int IDX_W     = $clog2(NUM_ACT);

  // forward word: code, three bypass flags, parameter
  function automatic logic [ACT_W-1:0] fwd_word(logic [2:0] code, logic [2:0] byp,
                                                logic [9:0] prm);
    return {code, byp, prm};
  endfunction

  // VID word: two spare zero bits, code, VID
  function automatic logic [ACT_W-1:0] vid_word(logic [1:0] code, logic [11:0] vid);
    return {2'b00, code, vid};
  endfunction

  // selector word: drop code over the request flags
  function automatic logic [ACT_W-1:0] sel_word(logic drop, logic [NUM_ACT-1:0] flags);
    return {1'b0, drop, flags};
  endfunction
endpackage

// File: rtl/act_word_former.sv
module act_word_former
  import act_pack_pkg::*;
(
  input  logic [2:0]                   fwd_code_i,
  input  logic [2:0]                   fwd_bypass_i,
  input  logic [9:0]                   fwd_data_i,
  input  logic [1:0]                   ovid_code_i,
  input  logic [11:0]                  ovid_i,
  input  logic [1:0]                   ivid_code_i,
  input  logic [11:0]                  ivid_i,
  input  logic [PLAIN_ACT*ACT_W-1:0]   plain_data_i,
  output logic [NUM_ACT-1:0][ACT_W-1:0] words_o
);
  assign words_o[0] = fwd_word(fwd_code_i, fwd_bypass_i, fwd_data_i);
  assign words_o[1] = vid_word(ovid_code_i, ovid_i);
  assign words_o[2] = vid_word(ivid_code_i, ivid_i);

  // remaining actions pass their word through unchanged
  for (genvar k = 0; k < PLAIN_ACT; k++) begin : g_plain
    assign words_o[FIXED_ACT+k] = plain_data_i[k*ACT_W +: ACT_W];
  end
endmodule

// File: rtl/act_scan_ctrl.sv
module act_scan_ctrl
  import act_pack_pkg::*;
#(
  parameter int NUM_SLOT = 4,
  localparam int SLOT_W  = $clog2(NUM_SLOT),
  localparam int CNT_W   = $clog2(NUM_SLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NUM_ACT-1:0] act_sel_i,
  output logic              capture_o,
  output logic              busy_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              place_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              done_o,
  output logic              ovf_o
);
  localparam logic [CNT_W-1:0] TOP_SLOT = CNT_W'(NUM_SLOT - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_SLOT);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ACT - 1);

  logic               busy_q, done_q, ovf_q;
  logic [IDX_W-1:0]   idx_q;
  logic [CNT_W-1:0]   used_q;
  logic [NUM_ACT-1:0] flags_q;    // precedence order, forward at index 0
  logic [NUM_ACT-1:0] flags_prec;

  // named internal events
  logic cur_req, slots_full, abort_evt, place_evt, last_evt;

  for (genvar p = 0; p < NUM_ACT; p++) begin : g_rev
    assign flags_prec[p] = act_sel_i[NUM_ACT-1-p];
  end

  assign capture_o  = start_i && !busy_q;
  assign cur_req    = busy_q && flags_q[idx_q];
  assign slots_full = (used_q == FULL_CNT);
  assign abort_evt  = cur_req && slots_full;
  assign place_evt  = cur_req && !slots_full;
  assign last_evt   = busy_q && (idx_q == LAST_IDX) && !abort_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      used_q  <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      done_q <= abort_evt || last_evt;
      ovf_q  <= abort_evt;
      if (capture_o) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        used_q  <= '0;
        flags_q <= flags_prec;
      end else if (busy_q) begin
        idx_q <= idx_q + IDX_W'(1);
        if (place_evt) used_q <= used_q + CNT_W'(1);
        if (abort_evt || last_evt) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign idx_o   = idx_q;
  assign place_o = place_evt;
  assign slot_o  = SLOT_W'(TOP_SLOT - used_q);
  assign done_o  = done_q;
  assign ovf_o   = ovf_q;

  // R7: overflow is only ever reported together with completion
  assert_ovf_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> done_q);
  // R7: slot usage never exceeds the slot count
  assert_used_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= FULL_CNT);
  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: a clean finish follows examination of the last action
  assert_clean_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ovf_q) |-> ($past(idx_q) == LAST_IDX));
endmodule

// File: rtl/act_slot_bank.sv
module act_slot_bank
  import act_pack_pkg::*;
#(
  parameter int NUM_SLOT = 4,
  localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear_i,
  input  logic                      wr_i,
  input  logic [SLOT_W-1:0]         wr_slot_i,
  input  logic [ACT_W-1:0]          wr_data_i,
  output logic [NUM_SLOT*ACT_W-1:0] slots_o
);
  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
    logic [ACT_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    slot_q <= '0;
      else if (clear_i)                              slot_q <= '0;
      else if (wr_i && (wr_slot_i == SLOT_W'(k)))    slot_q <= wr_data_i;
    end
    assign slots_o[k*ACT_W +: ACT_W] = slot_q;
  end
endmodule

// File: rtl/act_slot_packer.sv
module act_slot_packer
  import act_pack_pkg::*;
#(
  parameter int NUM_SLOT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [13:0]                 act_sel_i,
  input  logic                        drop_i,
  input  logic [2:0]                  fwd_code_i,
  input  logic [2:0]                  fwd_bypass_i,
  input  logic [9:0]                  fwd_data_i,
  input  logic [1:0]                  ovid_code_i,
  input  logic [11:0]                 ovid_i,
  input  logic [1:0]                  ivid_code_i,
  input  logic [11:0]                 ivid_i,
  input  logic [175:0]                plain_data_i,
  output logic [NUM_SLOT*16-1:0]      slots_o,
  output logic [15:0]                 sel_word_o,
  output logic                        done_o,
  output logic                        ovf_o
);
  localparam int SLOT_W = $clog2(NUM_SLOT);

  logic [NUM_ACT-1:0][ACT_W-1:0] words_in, words_q;
  logic [ACT_W-1:0]  sel_q;
  logic              capture, busy, place;
  logic [IDX_W-1:0]  idx;
  logic [SLOT_W-1:0] slot;

  act_word_former u_former (
    .fwd_code_i   (fwd_code_i),
    .fwd_bypass_i (fwd_bypass_i),
    .fwd_data_i   (fwd_data_i),
    .ovid_code_i  (ovid_code_i),
    .ovid_i       (ovid_i),
    .ivid_code_i  (ivid_code_i),
    .ivid_i       (ivid_i),
    .plain_data_i (plain_data_i),
    .words_o      (words_in)
  );

  act_scan_ctrl #(.NUM_SLOT(NUM_SLOT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .act_sel_i (act_sel_i),
    .capture_o (capture),
    .busy_o    (busy),
    .idx_o     (idx),
    .place_o   (place),
    .slot_o    (slot),
    .done_o    (done_o),
    .ovf_o     (ovf_o)
  );

  // hold every action word for the whole scan
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      sel_q   <= '0;
    end else if (capture) begin
      words_q <= words_in;
      sel_q   <= sel_word(drop_i, act_sel_i);
    end
  end

  act_slot_bank #(.NUM_SLOT(NUM_SLOT)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (capture),
    .wr_i      (place),
    .wr_slot_i (slot),
    .wr_data_i (words_q[idx]),
    .slots_o   (slots_o)
  );

  assign sel_word_o = sel_q;

  // R9: a new scan starts from an all-zero slot array
  assert_clear_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (slots_o == '0));
  // R10: selector word is not re-captured during a scan
  assert_hold_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sel_word_o));
endmodule

// File: tb/sim_act_slot_packer.sv
module sim_act_slot_packer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, start_i, drop_i;
  logic [13:0]  act_sel_i;
  logic [2:0]   fwd_code_i, fwd_bypass_i;
  logic [9:0]   fwd_data_i;
  logic [1:0]   ovid_code_i, ivid_code_i;
  logic [11:0]  ovid_i, ivid_i;
  logic [175:0] plain_data_i;
  logic [63:0]  slots_o;
  logic [15:0]  sel_word_o;
  logic         done_o, ovf_o;

  act_slot_packer u0 (.*);

  typedef struct {
    logic [63:0] slots;
    logic [15:0] sel;
    logic        ovf;
    int          lat;
    int          t0;
    string       name;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_bad = 0, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // monitor: pop the scoreboard on each completion pulse
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        chk("R8 unexpected done", 1, 0);
      end else begin
        e = sb.pop_front();
        chk({"R7 ovf flag ", e.name}, ovf_o, e.ovf);
        chk({"R7 R8 latency ", e.name}, cyc - e.t0, e.lat);
        chk({"R4 selector ", e.name}, sel_word_o, e.sel);
        if (!e.ovf)
          chk({"R2 R3 R5 R6 R9 R11 slots ", e.name}, slots_o, e.slots);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
      report();
      $finish;
    end
  end

  task automatic run(string name, logic [13:0] sel, logic drp, logic [2:0] fc,
                     logic [2:0] fb, logic [9:0] fd, logic [1:0] oc, logic [11:0] ov,
                     logic [1:0] ic, logic [11:0] iv, logic [15:0] seed, bit noise);
    exp_t e;
    logic [175:0] pl;
    logic [15:0]  w;
    int used;
    for (int k = 0; k < 11; k++) pl[k*16 +: 16] = seed ^ 16'(16'h1357 * (k + 1));
    e.slots = '0;
    e.sel   = {1'b0, drp, sel};
    e.ovf   = 1'b0;
    e.lat   = 15;
    e.name  = name;
    used    = 0;
    for (int p = 0; p < 14; p++) begin
      if (sel[13-p] && !e.ovf) begin
        if (p == 0)      w = {fc, fb, fd};
        else if (p == 1) w = {2'b00, oc, ov};
        else if (p == 2) w = {2'b00, ic, iv};
        else             w = pl[(p-3)*16 +: 16];
        if (used == 4) begin
          e.ovf = 1'b1;
          e.lat = p + 2;
        end else begin
          e.slots[(3-used)*16 +: 16] = w;
          used++;
        end
      end
    end
    @(negedge clk);
    act_sel_i = sel; drop_i = drp; fwd_code_i = fc; fwd_bypass_i = fb;
    fwd_data_i = fd; ovid_code_i = oc; ovid_i = ov; ivid_code_i = ic; ivid_i = iv;
    plain_data_i = pl;
    start_i = 1'b1;
    e.t0 = cyc;
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
    if (noise) begin
      repeat (3) @(negedge clk);
      act_sel_i = ~sel; drop_i = ~drp; fwd_data_i = ~fd; plain_data_i = ~pl;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rnd;
    rst_n = 1'b0; start_i = 1'b0; drop_i = 1'b0; act_sel_i = '0;
    fwd_code_i = '0; fwd_bypass_i = '0; fwd_data_i = '0; ovid_code_i = '0;
    ovid_i = '0; ivid_code_i = '0; ivid_i = '0; plain_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset done", done_o, 0);
    chk("R1 reset ovf", ovf_o, 0);
    chk("R1 reset slots", slots_o, 0);
    chk("R1 reset selector", sel_word_o, 0);

    run("R9 empty with drop", 14'h0000, 1, 3'd5, 3'b101, 10'h2A5, 2'd1, 12'h123, 2'd2, 12'h456, 16'hBEEF, 0);
    run("R5 forward only", 14'h2000, 0, 3'd6, 3'b110, 10'h155, 2'd3, 12'hFFF, 2'd0, 12'h001, 16'h1234, 0);
    run("R6 top four", 14'h3C00, 1, 3'd1, 3'b011, 10'h3FF, 2'd2, 12'hABC, 2'd1, 12'h0F0, 16'h5A5A, 0);
    run("R2 sparse low", 14'h02A1, 0, 3'd0, 3'b000, 10'h000, 2'd0, 12'h000, 2'd0, 12'h000, 16'h0F0F, 0);
    run("R9 two low", 14'h000A, 1, 3'd2, 3'b100, 10'h0AA, 2'd1, 12'h321, 2'd3, 12'h654, 16'hC3C3, 0);
    run("R7 all fourteen", 14'h3FFF, 1, 3'd7, 3'b111, 10'h111, 2'd1, 12'h777, 2'd2, 12'h888, 16'h9999, 0);
    run("R7 fifth is last", 14'h2225, 0, 3'd4, 3'b010, 10'h222, 2'd2, 12'h999, 2'd1, 12'hAAA, 16'h7777, 0);
    run("R8 four at end", 14'h000F, 0, 3'd3, 3'b001, 10'h333, 2'd0, 12'hBBB, 2'd3, 12'hCCC, 16'h4444, 0);
    run("R10 busy start ignored", 14'h3C00, 0, 3'd2, 3'b101, 10'h0F0, 2'd1, 12'h0AB, 2'd2, 12'hCD0, 16'h6666, 1);

    rnd = 32'h1ACE_B00C;
    for (int n = 0; n < 8; n++) begin
      rnd = rnd * 32'd1103515245 + 32'd12345;
      run("R2 R7 mixed", rnd[29:16], rnd[3], rnd[6:4], rnd[9:7], rnd[19:10],
          rnd[21:20], rnd[31:20], rnd[1:0], rnd[13:2], rnd[15:0], 0);
    end

    report();
    $finish;
  end
endmodule